// File: doc/BRIEF.md
# Serial Register Programming Slave

This block lets an external controller read and write a device's configuration registers over four wires: an active-low chip select, a serial clock, a data input and a data output. A strap input chooses serial programming; when the strap is low the block stays idle. The serial pins are brought into the core clock domain through synchronizers. The block then works from the detected edges of the serial clock. It drives a single-cycle register-file port and takes its read data back combinationally from that port.

Each frame opens with a start bit of 1. An operation bit follows, 1 for a read and 0 for a write. Then come an address and a data field, each sent MSB first. Input bits are sampled on serial clock falls, and read data leaves on serial clock rises. A write is not applied on the fall that carries its last bit. It is applied on the fall after that. That fall can be the start bit of the next frame, so frames may run back to back with no gap. A trailing clock is needed only after the last frame, and it still counts when chip select has already gone high.

Top module: `ser_regprog_slave`

## Requirements
- R1: While `ser_mode_i` is low, no frame is accepted, `reg_we_o` and `reg_re_o` stay low, and `sdo_o` is 0.
- R2: A frame can start only after a high-to-low transition of `scs_ni`. If the first bit sampled after that transition is 0, every following bit is ignored, with no write and no read data, until chip select goes high and then low again.
- R3: Bits are sampled on falling edges of `sclk_i` in this order: start bit (1), operation bit (0 = write, 1 = read), ADDR_W address bits MSB first, DATA_W data bits MSB first. A write frame is 2+ADDR_W+DATA_W bits long.
- R4: A write drives `reg_we_o` high for exactly one core clock, with the frame's address and data. This happens on the `sclk_i` fall that follows the last data bit, and never earlier.
- R5: Chip select may rise before the fall that carries the last bit. The frame still completes, and the trailing fall still commits the write.
- R6: With chip select held low, the fall that commits a write also samples the start bit of the next frame, so consecutive frames need no gap.
- R7: For a read, `reg_re_o` pulses for one core clock with the address once the last address bit is sampled. The value on `reg_rdata_i` is then shifted out on `sdo_o` MSB first, one bit per `sclk_i` rise, starting at the rise right after the last address bit.
- R8: `sdo_o` is 0 whenever no read data bit is being presented, including during write frames and after the last read data bit.
- R9: After reset, `reg_we_o`, `reg_re_o` and `sdo_o` are 0.
- R10: A read frame also spans 2+ADDR_W+DATA_W falls. The bits after the address are ignored, and a read never produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_mode_i | input | 1 | High selects serial programming |
| scs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data |

## Verification
The bench looks for a write strobe that shows up on the last data bit instead of the following fall. A design with that fault would commit one clock early, which the count check taken before the trailing clock exposes. It also raises chip select before the final bit. A design that aborts on that rise would lose the write. Back-to-back frames that write and then read the same address show whether the deferred commit collides with the next start bit, or whether the read returns the stale value. Zero start bits, the strap held low, and random mixed frames check that ignored traffic leaves the register file alone and that the data output stays at 0 outside read data.

// File: rtl/ser_regprog_pkg.sv
package ser_regprog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_SKIP  = 2'd3
  } frm_state_e;

  // index of the sync bus bits
  localparam int unsigned SIG_CS   = 0;
  localparam int unsigned SIG_SCLK = 1;
  localparam int unsigned SIG_SDI  = 2;
  localparam int unsigned SIG_N    = 3;
endpackage

// File: rtl/ser_regprog_sync.sv
module ser_regprog_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {(STAGES+1){RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-1:0], din_i[g]};
    end
    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/ser_regprog_frame.sv
module ser_regprog_frame
  import ser_regprog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_lvl_i,
  input  logic              cs_fall_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned SH_W      = ADDR_W + DATA_W;
  localparam int unsigned LAST_CNT  = 1 + ADDR_W + DATA_W;
  localparam int unsigned ADDR_CNT  = 1 + ADDR_W;
  localparam int unsigned CNT_W     = $clog2(LAST_CNT + 1);

  frm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_nx;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              op_q, op_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              we_d, re_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    op_d    = op_q;
    pend_d  = pend_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    addr_d  = addr_o;
    wdata_d = wdata_o;

    // deferred commit: any fall after the frame end, regardless of chip select
    if (sclk_fall_i && pend_q) begin
      we_d    = 1'b1;
      addr_d  = pa_q;
      wdata_d = pd_q;
      pend_d  = 1'b0;
    end

    if (!mode_i) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      we_d    = 1'b0;
    end else if (cs_fall_i) begin
      state_d = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_HUNT: begin
          if (cs_lvl_i) state_d = ST_IDLE;
          else if (sclk_fall_i) begin
            cnt_d   = '0;
            state_d = sdi_i ? ST_SHIFT : ST_SKIP;
          end
        end
        ST_SKIP: if (cs_lvl_i) state_d = ST_IDLE;
        ST_SHIFT: begin
          if (sclk_fall_i) begin
            cnt_d = cnt_nx;
            if (cnt_q == '0) op_d = sdi_i;
            else             sh_d = {sh_q[SH_W-2:0], sdi_i};
            if (cnt_nx == CNT_W'(ADDR_CNT) && op_q) begin
              re_d   = 1'b1;
              addr_d = {sh_q[ADDR_W-2:0], sdi_i};
            end
            if (cnt_nx == CNT_W'(LAST_CNT)) begin
              if (!op_q) begin
                pend_d = 1'b1;
                pa_d   = sh_q[SH_W-2:DATA_W-1];
                pd_d   = {sh_q[DATA_W-2:0], sdi_i};
              end
              state_d = cs_lvl_i ? ST_IDLE : ST_HUNT;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      op_q    <= 1'b0;
      pend_q  <= 1'b0;
      pa_q    <= '0;
      pd_q    <= '0;
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      op_q    <= op_d;
      pend_q  <= pend_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      we_o    <= we_d;
      re_o    <= re_d;
      addr_o  <= addr_d;
      wdata_o <= wdata_d;
    end
  end

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R4
  AST_RE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> !re_o); // R7
  AST_WE_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(mode_i)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (cnt_q < CNT_W'(LAST_CNT))); // R3
  AST_SKIP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |=> !re_o); // R2
endmodule

// File: rtl/ser_regprog_tx.sv
module ser_regprog_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              sdo_o
);
  localparam int unsigned LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else if (!mode_i) begin
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= LEFT_W'(DATA_W);
    end else if (shift_i) begin
      if (left_q != '0) begin
        sdo_o  <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        left_q <= left_q - LEFT_W'(1);
      end else begin
        sdo_o <= 1'b0;
      end
    end
  end

  AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LEFT_W'(DATA_W)); // R7
endmodule

// File: rtl/ser_regprog_slave.sv
module ser_regprog_slave
  import ser_regprog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic              scs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam logic [SIG_N-1:0] SYNC_RST = SIG_N'((1 << SIG_CS) | (1 << SIG_SCLK));

  logic [SIG_N-1:0] raw, lvl, rise, fall;

  assign raw[SIG_CS]   = scs_ni;
  assign raw[SIG_SCLK] = sclk_i;
  assign raw[SIG_SDI]  = sdi_i;

  ser_regprog_sync #(
    .N      (SIG_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (raw),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  ser_regprog_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (ser_mode_i),
    .cs_lvl_i   (lvl[SIG_CS]),
    .cs_fall_i  (fall[SIG_CS]),
    .sclk_fall_i(fall[SIG_SCLK]),
    .sdi_i      (lvl[SIG_SDI]),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o)
  );

  ser_regprog_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ser_mode_i),
    .load_i (reg_re_o),
    .data_i (reg_rdata_i),
    .shift_i(rise[SIG_SCLK]),
    .sdo_o  (sdo_o)
  );

  AST_WE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(fall[SIG_SCLK])); // R4
  AST_RE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> $past(fall[SIG_SCLK])); // R7
  AST_SDO_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_o != $past(sdo_o)) |-> ($past(rise[SIG_SCLK]) || !$past(ser_mode_i))); // R8
  AST_SDO_MODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_mode_i |=> !sdo_o); // R1
  AST_NO_WE_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R10
endmodule

// File: tb/sim_ser_regprog_slave.sv
module sim_ser_regprog_slave;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       we, re;
  logic [7:0] addr, wdata, rdata;

  logic [7:0] bmem [256];
  logic [7:0] exp_mem [256];
  int         wcnt = 0;
  int         wcnt_exp = 0;
  logic [7:0] last_wa, last_wd;
  bit         pend_v = 0;
  logic [7:0] pend_a, pend_d;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  ser_regprog_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_i(mode), .scs_ni(cs_n),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .reg_we_o(we), .reg_re_o(re),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 5) ^ (i >> 3));
  endfunction

  assign rdata = bmem[addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= init_val(i);
    end else if (we) begin
      bmem[addr] <= wdata;
      wcnt       <= wcnt + 1;
      last_wa    <= addr;
      last_wd    <= wdata;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    sdi = b;
    repeat (H) @(posedge clk);
    sclk = 1'b0;
    repeat (H) @(posedge clk);
    sclk = 1'b1;
    repeat (H) @(posedge clk);
    @(negedge clk);
    s = sdo;
  endtask

  task automatic commit_check();
    if (pend_v) begin
      chk(wcnt == wcnt_exp + 1, "R4", "commit count", wcnt, wcnt_exp + 1);
      chk(last_wa == pend_a, "R4", "commit addr", last_wa, pend_a);
      chk(last_wd == pend_d, "R4", "commit data", last_wd, pend_d);
      wcnt_exp = wcnt;
      exp_mem[pend_a] = pend_d;
      pend_v = 0;
    end
  endtask

  // one full frame; early=1 raises chip select before the last fall (R5)
  task automatic send_frame(input logic op, input logic [7:0] a,
                            input logic [7:0] d, input bit early);
    logic [17:0] fr;
    logic [7:0]  rd;
    logic        s;
    if (cs_n) begin
      cs_n = 1'b0;
      repeat (H) @(posedge clk);
    end
    fr = {1'b1, op, a, d};
    rd = '0;
    for (int i = 0; i < 18; i++) begin
      if (i == 17 && early) begin
        cs_n = 1'b1;
        repeat (3) @(posedge clk);
      end
      bit_cyc(fr[17-i], s);
      if (i == 0) commit_check(); // R6
      if (op && i >= 9 && i <= 16) rd[16-i] = s;
      else if (s !== 1'b0) chk(0, "R8", "sdo idle", s, 0);
    end
    if (op) begin
      chk(rd == exp_mem[a], "R7", "read data", rd, exp_mem[a]);
      chk(wcnt == wcnt_exp, "R10", "read wrote", wcnt, wcnt_exp);
    end else begin
      chk(wcnt == wcnt_exp, "R4", "early commit", wcnt, wcnt_exp);
      pend_v = 1; pend_a = a; pend_d = d;
    end
  endtask

  task automatic trail();
    logic s;
    bit_cyc(1'b0, s);
    commit_check();
    chk(s == 1'b0, "R8", "sdo trailing", s, 0);
    cs_n = 1'b1;
    repeat (H) @(posedge clk);
  endtask

  task automatic raw_frame(input logic [17:0] fr, inout logic s_or);
    logic s;
    for (int i = 0; i < 18; i++) begin
      bit_cyc(fr[17-i], s);
      s_or |= s;
    end
  endtask

  initial begin
    logic s_or;
    int   grp, op_r;
    void'($urandom(32'h5EED_0413));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(we == 0, "R9", "we reset", we, 0);
    chk(re == 0, "R9", "re reset", re, 0);
    chk(sdo == 0, "R9", "sdo reset", sdo, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 R4: plain write, then read back (R7)
    send_frame(1'b0, 8'hA5, 8'h3C, 0);
    trail();
    send_frame(1'b1, 8'hA5, 8'h00, 0);
    trail();

    // R5: chip select rises before the last bit
    send_frame(1'b0, 8'h12, 8'hC3, 1);
    trail();
    send_frame(1'b1, 8'h12, 8'h00, 1);
    trail();

    // R6: back-to-back write, write, read to the same address
    send_frame(1'b0, 8'h40, 8'h81, 0);
    send_frame(1'b0, 8'h40, 8'h7E, 0);
    send_frame(1'b1, 8'h40, 8'h00, 0);
    trail();

    // R2: zero start bit, then a valid-looking frame in the same select
    cs_n = 1'b0;
    repeat (H) @(posedge clk);
    s_or = 1'b0;
    raw_frame({2'b00, 8'h55, 8'hEE}, s_or);
    raw_frame({2'b10, 8'h55, 8'hEE}, s_or);
    raw_frame({2'b11, 8'h55, 8'h00}, s_or);
    cs_n = 1'b1;
    repeat (H) @(posedge clk);
    chk(wcnt == wcnt_exp, "R2", "ignored frame wrote", wcnt, wcnt_exp);
    chk(s_or == 1'b0, "R2", "ignored frame sdo", s_or, 0);
    send_frame(1'b1, 8'h55, 8'h00, 0);
    trail();

    // R1: strap low
    mode = 1'b0;
    repeat (4) @(posedge clk);
    cs_n = 1'b0;
    repeat (H) @(posedge clk);
    s_or = 1'b0;
    raw_frame({2'b10, 8'h77, 8'h99}, s_or);
    raw_frame({2'b11, 8'h77, 8'h00}, s_or);
    cs_n = 1'b1;
    repeat (H) @(posedge clk);
    chk(wcnt == wcnt_exp, "R1", "write in parallel mode", wcnt, wcnt_exp);
    chk(s_or == 1'b0, "R1", "sdo in parallel mode", s_or, 0);
    mode = 1'b1;
    repeat (4) @(posedge clk);
    send_frame(1'b1, 8'h77, 8'h00, 0);
    trail();

    // random groups of back-to-back frames
    for (int g = 0; g < 40; g++) begin
      grp = 1 + int'($urandom_range(2));
      for (int k = 0; k < grp; k++) begin
        op_r = int'($urandom_range(1));
        send_frame(op_r[0], 8'($urandom_range(15) * 16 + g % 4),
                   8'($urandom), (k == grp - 1) && ($urandom_range(3) == 0));
      end
      trail();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule